// File: doc/BRIEF.md
# Segmented Comparand Loader with Automatic Compare Trigger

This block assembles a wide search key for a content-addressable lookup out of narrow bus writes. A write segment counter picks which slice of the target register each write fills; three targets exist: the comparand and two mask registers. A write to the comparand that lands on the final segment of the configured window raises a one-cycle compare request on its own, so software never issues a separate "go" for a search. The lookup array that consumes the request sits outside this block.

Both the comparand and the second mask can be rotated by one bit per command, in either direction, with the bit that falls off one end coming back in at the other. A write may be masked: bits whose mask bit is 1 keep their old value, and the caller picks which of the two masks guards the write. Another select chooses which mask is presented beside the comparand for the search. A separate read segment counter returns any of the three registers one slice at a time.

The segment window of each counter is programmable (first and last index), which allows keys narrower than the full register and sets where the automatic compare fires.

Top module: `seg_comparand_loader`

## Requirements
- R1: After reset the comparand, both masks, rd_data and cmp_req are zero, both segment counters are at 0, and both windows span 0 to NUM_SEGS-1.
- R2: A write (wr_en=1, cfg_en=0) fills bits [s*SEG_W +: SEG_W] of the register named by wr_dest (0 comparand, 1 first mask, 2 second mask, 3 none) where s is wr_seg; wr_seg then steps by one, or returns to the window's first index when it was at the window's last index or at NUM_SEGS-1, and stays unchanged in cycles without a write.
- R3: cmp_req is high for exactly the one cycle after a write to the comparand made while wr_seg was at its window end (last index or NUM_SEGS-1); writes to the masks and other comparand writes never raise it.
- R4: With wr_masked=1, every destination bit whose bit in the guarding mask (wr_mask_sel 0 first mask, 1 second mask) is 1 keeps its old value, while the others take wr_data.
- R5: A shift command (shift_en=1, shift_tgt=0) rotates the comparand by one bit, toward the MSB when shift_dir=0 with the old MSB entering bit 0, and toward the LSB when shift_dir=1 with the old bit 0 entering the MSB.
- R6: With shift_tgt=1 the same one-bit rotation applies to the second mask and leaves the comparand unchanged.
- R7: A shift command in the same cycle as a write or a configuration load is ignored.
- R8: A read (rd_en=1, cfg_en=0) returns on rd_data in the next cycle the slice at rd_seg of the register named by rd_src (same encoding as wr_dest, 3 returns zero) as it was before that cycle's write; rd_seg steps with the same wrap rule over its own window, holds otherwise, and writes never move it.
- R9: cmp_mask equals the first mask when cmp_mask_sel=0 and the second mask when cmp_mask_sel=1, in the same cycle.
- R10: A configuration load (cfg_en=1) sets both windows and places each counter at its window's first index; a write or read in that cycle is ignored and raises no compare request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Load both segment windows |
| cfg_wr_first | input | CNT_W | First index of the write window |
| cfg_wr_last | input | CNT_W | Last index of the write window |
| cfg_rd_first | input | CNT_W | First index of the read window |
| cfg_rd_last | input | CNT_W | Last index of the read window |
| wr_en | input | 1 | Write one slice |
| wr_dest | input | 2 | Write target: 0 comparand, 1 first mask, 2 second mask, 3 none |
| wr_data | input | SEG_W | Slice data |
| wr_masked | input | 1 | Apply mask protection to this write |
| wr_mask_sel | input | 1 | Guarding mask: 0 first, 1 second |
| shift_en | input | 1 | One-bit rotate command |
| shift_tgt | input | 1 | Rotate target: 0 comparand, 1 second mask |
| shift_dir | input | 1 | 0 toward MSB, 1 toward LSB |
| cmp_mask_sel | input | 1 | Mask presented for search: 0 first, 1 second |
| rd_en | input | 1 | Read one slice |
| rd_src | input | 2 | Read source, encoded as wr_dest |
| rd_data | output | SEG_W | Slice returned by the last read |
| wr_seg | output | CNT_W | Current write segment index |
| rd_seg | output | CNT_W | Current read segment index |
| cmp_req | output | 1 | One-cycle compare request |
| cmp_key | output | SEG_W*NUM_SEGS | Comparand |
| cmp_mask | output | SEG_W*NUM_SEGS | Selected search mask |

## Verification
The bench builds the block with SEG_W=32 and NUM_SEGS=4, a 128-bit key with two-bit counters, rather than the 64-bit default. Four segments make room for windows that start above zero, end below the top index, and start above their end, so the return-to-first rule and the compare trigger at the highest index are both reached. The wider word also keeps rotations that carry a bit across the word ends apart from carries across slice boundaries.

// File: rtl/clc_pkg.sv
package clc_pkg;
    typedef enum logic [1:0] {
        REG_CMP  = 2'd0,
        REG_MSK1 = 2'd1,
        REG_MSK2 = 2'd2,
        REG_NONE = 2'd3
    } clc_reg_e;

    function automatic int cnt_width(input int segs);
        return (segs > 1) ? $clog2(segs) : 1;
    endfunction
endpackage

// File: rtl/clc_seg_counter.sv
module clc_seg_counter #(
    parameter int CNT_W = 1,
    parameter int LAST  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] first_in,
    input  logic [CNT_W-1:0] last_in,
    input  logic             step,
    output logic [CNT_W-1:0] seg,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LAST);

    typedef struct packed {
        logic [CNT_W-1:0] seg;
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] last;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    function automatic logic [CNT_W-1:0] clip(input logic [CNT_W-1:0] v);
        return (v > TOP) ? TOP : v;
    endfunction

    always_comb begin
        cnt_d  = cnt_q;
        at_end = (cnt_q.seg == cnt_q.last) || (cnt_q.seg == TOP);
        if (load) begin
            cnt_d.first = clip(first_in);
            cnt_d.last  = clip(last_in);
            cnt_d.seg   = clip(first_in);
        end else if (step) begin
            cnt_d.seg = at_end ? cnt_q.first : cnt_q.seg + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.seg   <= '0;
            cnt_q.first <= '0;
            cnt_q.last  <= TOP;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign seg = cnt_q.seg;
endmodule

// File: rtl/clc_rotator.sv
module clc_rotator #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    input  logic         dir_right,
    output logic [W-1:0] dout
);
    always_comb begin
        if (dir_right) dout = {din[0], din[W-1:1]};
        else           dout = {din[W-2:0], din[W-1]};
    end
endmodule

// File: rtl/clc_slice_merge.sv
module clc_slice_merge #(
    parameter int SEG_W    = 32,
    parameter int NUM_SEGS = 2,
    parameter int CNT_W    = 1,
    localparam int W       = SEG_W * NUM_SEGS
) (
    input  logic [W-1:0]     old_word,
    input  logic [W-1:0]     mask_word,
    input  logic [SEG_W-1:0] data,
    input  logic [CNT_W-1:0] seg,
    input  logic             masked,
    output logic [W-1:0]     new_word
);
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_slice
        logic [SEG_W-1:0] keep;
        logic [SEG_W-1:0] old_s;
        assign old_s = old_word[g*SEG_W +: SEG_W];
        assign keep  = masked ? mask_word[g*SEG_W +: SEG_W] : '0;
        assign new_word[g*SEG_W +: SEG_W] =
            (seg == CNT_W'(g)) ? ((old_s & keep) | (data & ~keep)) : old_s;
    end
endmodule

// File: rtl/seg_comparand_loader.sv
module seg_comparand_loader
    import clc_pkg::*;
#(
    parameter int SEG_W    = 32,
    parameter int NUM_SEGS = 2,
    localparam int WORD_W  = SEG_W * NUM_SEGS,
    localparam int CNT_W   = cnt_width(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CNT_W-1:0]  cfg_wr_first,
    input  logic [CNT_W-1:0]  cfg_wr_last,
    input  logic [CNT_W-1:0]  cfg_rd_first,
    input  logic [CNT_W-1:0]  cfg_rd_last,
    input  logic              wr_en,
    input  logic [1:0]        wr_dest,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              wr_masked,
    input  logic              wr_mask_sel,
    input  logic              shift_en,
    input  logic              shift_tgt,
    input  logic              shift_dir,
    input  logic              cmp_mask_sel,
    input  logic              rd_en,
    input  logic [1:0]        rd_src,
    output logic [SEG_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  wr_seg,
    output logic [CNT_W-1:0]  rd_seg,
    output logic              cmp_req,
    output logic [WORD_W-1:0] cmp_key,
    output logic [WORD_W-1:0] cmp_mask
);
    typedef struct packed {
        logic [WORD_W-1:0] comp;
        logic [WORD_W-1:0] msk1;
        logic [WORD_W-1:0] msk2;
        logic              req;
        logic [SEG_W-1:0]  rd_data;
    } state_t;

    state_t st_d, st_q;

    clc_reg_e          dest, src;
    logic              wr_go, rd_go, sh_go;
    logic              wr_at_end, rd_at_end;
    logic [WORD_W-1:0] wr_old, wr_guard, wr_new;
    logic [WORD_W-1:0] comp_rot, msk2_rot, rd_word;

    assign dest  = clc_reg_e'(wr_dest);
    assign src   = clc_reg_e'(rd_src);
    assign wr_go = wr_en && !cfg_en;
    assign rd_go = rd_en && !cfg_en;
    assign sh_go = shift_en && !wr_en && !cfg_en;

    // Write and read segment counters, each with its own window
    clc_seg_counter #(.CNT_W(CNT_W), .LAST(NUM_SEGS - 1)) u_wr_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_en),
        .first_in (cfg_wr_first),
        .last_in  (cfg_wr_last),
        .step     (wr_go),
        .seg      (wr_seg),
        .at_end   (wr_at_end)
    );

    clc_seg_counter #(.CNT_W(CNT_W), .LAST(NUM_SEGS - 1)) u_rd_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_en),
        .first_in (cfg_rd_first),
        .last_in  (cfg_rd_last),
        .step     (rd_go),
        .seg      (rd_seg),
        .at_end   (rd_at_end)
    );

    // Operand selection for the slice merge
    always_comb begin
        unique case (dest)
            REG_CMP:  wr_old = st_q.comp;
            REG_MSK1: wr_old = st_q.msk1;
            REG_MSK2: wr_old = st_q.msk2;
            default:  wr_old = '0;
        endcase
        wr_guard = wr_mask_sel ? st_q.msk2 : st_q.msk1;
    end

    clc_slice_merge #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .CNT_W(CNT_W)) u_merge (
        .old_word  (wr_old),
        .mask_word (wr_guard),
        .data      (wr_data),
        .seg       (wr_seg),
        .masked    (wr_masked),
        .new_word  (wr_new)
    );

    clc_rotator #(.W(WORD_W)) u_rot_comp (
        .din       (st_q.comp),
        .dir_right (shift_dir),
        .dout      (comp_rot)
    );

    clc_rotator #(.W(WORD_W)) u_rot_msk2 (
        .din       (st_q.msk2),
        .dir_right (shift_dir),
        .dout      (msk2_rot)
    );

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        unique case (src)
            REG_CMP:  rd_word = st_q.comp;
            REG_MSK1: rd_word = st_q.msk1;
            REG_MSK2: rd_word = st_q.msk2;
            default:  rd_word = '0;
        endcase

        if (wr_go) begin
            unique case (dest)
                REG_CMP: begin
                    st_d.comp = wr_new;
                    st_d.req  = wr_at_end;
                end
                REG_MSK1: st_d.msk1 = wr_new;
                REG_MSK2: st_d.msk2 = wr_new;
                default: ;
            endcase
        end else if (sh_go) begin
            if (shift_tgt) st_d.msk2 = msk2_rot;
            else           st_d.comp = comp_rot;
        end

        if (rd_go) begin
            st_d.rd_data = rd_word[int'(rd_seg)*SEG_W +: SEG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rd_data;
    assign cmp_req  = st_q.req;
    assign cmp_key  = st_q.comp;
    assign cmp_mask = cmp_mask_sel ? st_q.msk2 : st_q.msk1;

    logic unused_ok;
    assign unused_ok = rd_at_end;
endmodule

// File: rtl/seg_comparand_loader_chk.sv
module seg_comparand_loader_chk #(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              wr_en,
    input logic [1:0]        wr_dest,
    input logic              shift_en,
    input logic              shift_tgt,
    input logic              shift_dir,
    input logic              rd_en,
    input logic              wr_at_end,
    input logic              cmp_req,
    input logic [WORD_W-1:0] cmp_key,
    input logic [CNT_W-1:0]  wr_seg,
    input logic [CNT_W-1:0]  rd_seg
);
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |-> $past(wr_en && !cfg_en && wr_dest == 2'd0 && wr_at_end)); // R3

    AST_FINAL_WRITE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_en && wr_dest == 2'd0 && wr_at_end) |=> cmp_req); // R3

    AST_WSEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cfg_en) |=> $stable(wr_seg)); // R2

    AST_RSEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !cfg_en) |=> $stable(rd_seg)); // R8

    AST_ROT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en && !cfg_en && !shift_tgt && !shift_dir)
        |=> cmp_key == {$past(cmp_key[WORD_W-2:0]), $past(cmp_key[WORD_W-1])}); // R5

    AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en && !cfg_en && !shift_tgt && shift_dir)
        |=> cmp_key == {$past(cmp_key[0]), $past(cmp_key[WORD_W-1:1])}); // R5

    AST_MSK2_ROT_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_tgt && !wr_en) |=> $stable(cmp_key)); // R6

    AST_SHIFT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && shift_en && !shift_tgt && wr_dest != 2'd0) |=> $stable(cmp_key)); // R7
endmodule

bind seg_comparand_loader seg_comparand_loader_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .wr_en     (wr_en),
    .wr_dest   (wr_dest),
    .shift_en  (shift_en),
    .shift_tgt (shift_tgt),
    .shift_dir (shift_dir),
    .rd_en     (rd_en),
    .wr_at_end (wr_at_end),
    .cmp_req   (cmp_req),
    .cmp_key   (cmp_key),
    .wr_seg    (wr_seg),
    .rd_seg    (rd_seg)
);

// File: tb/seg_comparand_loader_test.sv
module seg_comparand_loader_test;
    localparam int SW = 32;
    localparam int NS = 4;
    localparam int W  = SW * NS;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [CW-1:0] cfg_wr_first = '0, cfg_wr_last = '0, cfg_rd_first = '0, cfg_rd_last = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_dest = '0;
    logic [SW-1:0] wr_data = '0;
    logic          wr_masked = 1'b0, wr_mask_sel = 1'b0;
    logic          shift_en = 1'b0, shift_tgt = 1'b0, shift_dir = 1'b0;
    logic          cmp_mask_sel = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_src = '0;
    logic [SW-1:0] rd_data;
    logic [CW-1:0] wr_seg, rd_seg;
    logic          cmp_req;
    logic [W-1:0]  cmp_key, cmp_mask;

    always #2 clk = ~clk;

    seg_comparand_loader #(.SEG_W(SW), .NUM_SEGS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
        .cfg_wr_first(cfg_wr_first), .cfg_wr_last(cfg_wr_last),
        .cfg_rd_first(cfg_rd_first), .cfg_rd_last(cfg_rd_last),
        .wr_en(wr_en), .wr_dest(wr_dest), .wr_data(wr_data),
        .wr_masked(wr_masked), .wr_mask_sel(wr_mask_sel),
        .shift_en(shift_en), .shift_tgt(shift_tgt), .shift_dir(shift_dir),
        .cmp_mask_sel(cmp_mask_sel), .rd_en(rd_en), .rd_src(rd_src),
        .rd_data(rd_data), .wr_seg(wr_seg), .rd_seg(rd_seg),
        .cmp_req(cmp_req), .cmp_key(cmp_key), .cmp_mask(cmp_mask)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] e_comp = '0, e_m1 = '0, e_m2 = '0;
    int e_wseg = 0, e_wfirst = 0, e_wlast = NS - 1;
    int e_rseg = 0, e_rfirst = 0, e_rlast = NS - 1;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int step_seg(input int s, input int f, input int l);
        return (s == l || s == NS - 1) ? f : s + 1;
    endfunction

    function automatic logic [W-1:0] reg_val(input logic [1:0] r);
        case (r)
            2'd0:    return e_comp;
            2'd1:    return e_m1;
            2'd2:    return e_m2;
            default: return '0;
        endcase
    endfunction

    // One slice write, optionally with a colliding shift of the comparand
    task automatic do_write(input logic [1:0] dest, input logic [SW-1:0] data,
                            input logic msk, input logic msel, input logic with_shift,
                            input string tag);
        logic [W-1:0] guard, word;
        bit fire;
        guard = msk ? (msel ? e_m2 : e_m1) : '0;
        word  = reg_val(dest);
        fire  = (dest == 2'd0) && (e_wseg == e_wlast || e_wseg == NS - 1);
        for (int i = 0; i < SW; i++) begin
            if (!guard[e_wseg*SW + i]) word[e_wseg*SW + i] = data[i];
        end
        case (dest)
            2'd0: e_comp = word;
            2'd1: e_m1 = word;
            2'd2: e_m2 = word;
            default: ;
        endcase
        e_wseg = step_seg(e_wseg, e_wfirst, e_wlast);
        @(negedge clk);
        wr_en = 1'b1; wr_dest = dest; wr_data = data;
        wr_masked = msk; wr_mask_sel = msel;
        shift_en = with_shift; shift_tgt = 1'b0; shift_dir = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; wr_masked = 1'b0; shift_en = 1'b0;
        chk({tag, " cmp_req"}, W'(cmp_req), W'(fire));
        chk({tag, " wr_seg"}, W'(wr_seg), W'(e_wseg));
        chk({tag, " cmp_key"}, cmp_key, e_comp);
        chk({tag, " cmp_mask"}, cmp_mask, cmp_mask_sel ? e_m2 : e_m1);
    endtask

    task automatic do_read(input logic [1:0] src, input string tag);
        logic [W-1:0] word;
        logic [SW-1:0] exp;
        int wseg_before;
        word = reg_val(src);
        exp  = word[e_rseg*SW +: SW];
        wseg_before = e_wseg;
        e_rseg = step_seg(e_rseg, e_rfirst, e_rlast);
        @(negedge clk);
        rd_en = 1'b1; rd_src = src;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " rd_data"}, W'(rd_data), W'(exp));
        chk({tag, " rd_seg"}, W'(rd_seg), W'(e_rseg));
        chk({tag, " wr_seg untouched"}, W'(wr_seg), W'(wseg_before));
    endtask

    task automatic do_shift(input logic tgt, input logic dir, input string tag);
        if (!tgt) e_comp = dir ? {e_comp[0], e_comp[W-1:1]} : {e_comp[W-2:0], e_comp[W-1]};
        else      e_m2   = dir ? {e_m2[0], e_m2[W-1:1]}     : {e_m2[W-2:0], e_m2[W-1]};
        @(negedge clk);
        shift_en = 1'b1; shift_tgt = tgt; shift_dir = dir;
        @(negedge clk);
        shift_en = 1'b0;
        chk({tag, " cmp_key"}, cmp_key, e_comp);
        chk({tag, " cmp_mask"}, cmp_mask, cmp_mask_sel ? e_m2 : e_m1);
    endtask

    task automatic do_cfg(input int wf, input int wl, input int rf, input int rl);
        e_wfirst = wf; e_wlast = wl; e_rfirst = rf; e_rlast = rl;
        e_wseg = wf; e_rseg = rf;
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_wr_first = CW'(wf); cfg_wr_last = CW'(wl);
        cfg_rd_first = CW'(rf); cfg_rd_last = CW'(rl);
        // Write, read and shift in the load cycle must all be ignored
        wr_en = 1'b1; wr_dest = 2'd0; wr_data = 32'hDEAD_BEEF;
        rd_en = 1'b1; rd_src = 2'd0; shift_en = 1'b1; shift_tgt = 1'b0;
        @(negedge clk);
        cfg_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; shift_en = 1'b0;
        chk("R10 wr_seg at first", W'(wr_seg), W'(wf));
        chk("R10 rd_seg at first", W'(rd_seg), W'(rf));
        chk("R10 write ignored", cmp_key, e_comp);
        chk("R10 no cmp_req", W'(cmp_req), '0);
    endtask

    task automatic t_reset();
        chk("R1 cmp_key", cmp_key, '0);
        chk("R1 cmp_mask", cmp_mask, '0);
        chk("R1 rd_data", W'(rd_data), '0);
        chk("R1 wr_seg", W'(wr_seg), '0);
        chk("R1 rd_seg", W'(rd_seg), '0);
        chk("R1 cmp_req", W'(cmp_req), '0);
    endtask

    task automatic t_fill();
        do_write(2'd0, 32'h8000_0011, 1'b0, 1'b0, 1'b0, "R2 fill s0");
        do_write(2'd0, 32'h2222_2222, 1'b0, 1'b0, 1'b0, "R2 fill s1");
        do_write(2'd0, 32'h3333_3333, 1'b0, 1'b0, 1'b0, "R2 fill s2");
        do_write(2'd0, 32'hC000_0001, 1'b0, 1'b0, 1'b0, "R3 fill final");
        @(negedge clk);
        chk("R3 pulse ends", W'(cmp_req), '0);
    endtask

    task automatic t_masks();
        cmp_mask_sel = 1'b0;
        for (int s = 0; s < NS; s++)
            do_write(2'd1, 32'hFFFF_0000 ^ (32'h1 << s), 1'b0, 1'b0, 1'b0, "R3 mask1 no pulse");
        chk("R9 select first mask", cmp_mask, e_m1);
        for (int s = 0; s < NS; s++)
            do_write(2'd2, 32'h0F0F_0F0F + s, 1'b0, 1'b0, 1'b0, "R3 mask2 no pulse");
        cmp_mask_sel = 1'b1;
        #1;
        chk("R9 select second mask", cmp_mask, e_m2);
        cmp_mask_sel = 1'b0;
        #1;
        chk("R9 back to first mask", cmp_mask, e_m1);
    endtask

    task automatic t_masked();
        for (int s = 0; s < NS; s++)
            do_write(2'd0, 32'hAAAA_5555, 1'b1, 1'b0, 1'b0, "R4 guard first mask");
        for (int s = 0; s < NS; s++)
            do_write(2'd0, 32'h1234_5678 << s, 1'b1, 1'b1, 1'b0, "R4 guard second mask");
        // Make both word ends 1 for the rotation tests
        do_write(2'd0, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R2 end bits s0");
        do_write(2'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R2 end bits s1");
        do_write(2'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R2 end bits s2");
        do_write(2'd0, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R3 end bits s3");
    endtask

    task automatic t_rotate();
        cmp_mask_sel = 1'b1;
        for (int k = 0; k < 3; k++) do_shift(1'b0, 1'b0, "R5 rotate left");
        for (int k = 0; k < 5; k++) do_shift(1'b0, 1'b1, "R5 rotate right");
        do_write(2'd2, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R2 mask2 s0 ends");
        do_write(2'd2, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R2 mask2 s1 ends");
        do_write(2'd2, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R2 mask2 s2 ends");
        do_write(2'd2, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R2 mask2 s3 ends");
        for (int k = 0; k < 2; k++) do_shift(1'b1, 1'b0, "R6 mask2 left");
        for (int k = 0; k < 3; k++) do_shift(1'b1, 1'b1, "R6 mask2 right");
        cmp_mask_sel = 1'b0;
    endtask

    task automatic t_collide();
        do_write(2'd0, 32'h5A5A_5A5A, 1'b0, 1'b0, 1'b1, "R7 write beats shift");
        do_write(2'd1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, "R7 shift dropped on mask write");
    endtask

    task automatic t_read();
        for (int s = 0; s < NS; s++) do_read(2'd0, "R8 read comparand");
        do_read(2'd1, "R8 read first mask");
        do_read(2'd2, "R8 read second mask");
        do_read(2'd3, "R8 read none is zero");
    endtask

    task automatic t_cfg();
        do_cfg(1, 2, 2, 3);
        do_write(2'd0, 32'h0101_0101, 1'b0, 1'b0, 1'b0, "R3 window mid no pulse");
        do_write(2'd0, 32'h0202_0202, 1'b0, 1'b0, 1'b0, "R3 window end pulse");
        do_write(2'd0, 32'h0303_0303, 1'b0, 1'b0, 1'b0, "R2 window wrap to first");
        do_read(2'd0, "R8 read window s2");
        do_read(2'd0, "R8 read window s3");
        do_read(2'd0, "R8 read window wrap");
        do_cfg(3, 1, 0, 0);
        do_write(2'd0, 32'h7777_0000, 1'b0, 1'b0, 1'b0, "R3 top index pulse");
        do_write(2'd0, 32'h0000_7777, 1'b0, 1'b0, 1'b0, "R3 top index pulse again");
        do_read(2'd1, "R8 single slice window");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_masks();
        t_masked();
        t_rotate();
        t_collide();
        t_read();
        t_cfg();
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule